// File: doc/BRIEF.md
# Carry and Status Flag Unit

This block keeps the two single-bit condition flags of a small 4-bit processor core: a carry flag and a status flag. When an instruction completes, the decoder presents a class code and the ALU presents its result signals: carry out, not-zero, compare result and bit-test result. The class code decides which flag, if any, takes which result. Set-carry, clear-carry and the two rotates change only the carry. Arithmetic, compare and bit-test instructions load the status flag from the matching ALU result.

Any branch or call class that is fetched forces the status flag to 1. This holds even when the core skips that instruction. The status flag also drives the condition input of conditional branches and calls.

On interrupt entry the stack logic reads both flags from the context outputs and saves them. A return-from-interrupt strobe writes the popped values back, and that write wins over any instruction update in the same cycle. A plain subroutine return leaves both flags alone.

Top module: `carry_status_flags`

## Requirements
- R1: While `rst_n` is low, both flags are held at 0, whatever the other inputs do.
- R2: When `instr_done` is 1 and `op_cls` is 1 (arithmetic with carry), both the carry flag and the status flag take `alu_carry` after the clock edge.
- R3: When `instr_done` is 1 and `op_cls` is 2 (arithmetic with zero test), the status flag takes `alu_nonzero` and the carry flag is unchanged.
- R4: When `instr_done` is 1, `op_cls` 3 (compare) loads the status flag from `cmp_result`, and `op_cls` 4 (bit test) loads it from `bit_result`. In both cases the carry flag is unchanged.
- R5: When `instr_done` is 1, `op_cls` 5 sets the carry flag to 1 and `op_cls` 6 clears it to 0. The status flag is unchanged.
- R6: When `instr_done` is 1, `op_cls` 7 (rotate left) loads the carry flag from `acc_val[DATA_W-1]`, and `op_cls` 8 (rotate right) loads it from `acc_val[0]`. The status flag is unchanged.
- R7: When `instr_done` is 1 and `op_cls` is 9 (branch or call fetched, executed or skipped), the status flag becomes 1 and the carry flag is unchanged.
- R8: Both flags hold their value when `instr_done` is 0. They also hold when `op_cls` is 0 (no flag effect), 10 (plain return), or any code from 11 to 15.
- R9: When `rti_restore` is 1, the carry flag takes `pop_carry` and the status flag takes `pop_status`, with or without `instr_done`. This restore takes priority over any instruction update in the same cycle.
- R10: `ctx_carry` and `ctx_status` always show the current flag values, and `branch_cond` always equals the current status flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Instruction-complete strobe that qualifies updates by class |
| op_cls | input | 4 | Instruction class code (see R2 to R8) |
| alu_carry | input | 1 | ALU carry / overflow out |
| alu_nonzero | input | 1 | ALU result not-zero |
| cmp_result | input | 1 | Compare result |
| bit_result | input | 1 | Bit-test result |
| acc_val | input | DATA_W | Accumulator before the rotate |
| rti_restore | input | 1 | Return-from-interrupt restore strobe |
| pop_carry | input | 1 | Carry value popped from the stack |
| pop_status | input | 1 | Status value popped from the stack |
| carry_flag | output | 1 | Current carry flag |
| status_flag | output | 1 | Current status flag |
| ctx_carry | output | 1 | Carry value for the interrupt context push |
| ctx_status | output | 1 | Status value for the interrupt context push |
| branch_cond | output | 1 | Condition for conditional branch and call |

## Verification
The bench builds the block with `DATA_W` = 4. With that width the rotate-left source (bit 3) and the rotate-right source (bit 0) are separate bits, so an implementation that takes the wrong end of the accumulator gives a different result. Random 4-bit accumulator values reach all sixteen patterns. The random 4-bit class codes hit every defined class and every unused code. Strobes and ALU results are drawn independently, which makes restore and instruction collisions in the same cycle frequent.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP      = 4'd0,
        OP_ARITH_CY = 4'd1,
        OP_ARITH_NZ = 4'd2,
        OP_COMPARE  = 4'd3,
        OP_BITTEST  = 4'd4,
        OP_SET_CY   = 4'd5,
        OP_CLR_CY   = 4'd6,
        OP_ROT_L    = 4'd7,
        OP_ROT_R    = 4'd8,
        OP_BRANCH   = 4'd9,
        OP_RETURN   = 4'd10
    } flag_op_e;
endpackage

// File: rtl/flagu_carry.sv
module flagu_carry
    import flagu_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  flag_op_e          op,
    input  logic              alu_carry,
    input  logic [DATA_W-1:0] acc,
    input  logic              restore,
    input  logic              pop_val,
    output logic              flag_q
);
    localparam int MSB = DATA_W - 1;

    logic nxt;
    logic hit;

    always_comb begin
        nxt = flag_q;
        hit = 1'b0;
        unique case (op)
            OP_ARITH_CY: begin nxt = alu_carry; hit = 1'b1; end
            OP_SET_CY:   begin nxt = 1'b1;      hit = 1'b1; end
            OP_CLR_CY:   begin nxt = 1'b0;      hit = 1'b1; end
            OP_ROT_L:    begin nxt = acc[MSB];  hit = 1'b1; end
            OP_ROT_R:    begin nxt = acc[0];    hit = 1'b1; end
            default:     begin nxt = flag_q;    hit = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (restore) begin
            flag_q <= pop_val;
        end else if (upd_en && hit) begin
            flag_q <= nxt;
        end
    end
endmodule

// File: rtl/flagu_status.sv
module flagu_status
    import flagu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     upd_en,
    input  flag_op_e op,
    input  logic     alu_carry,
    input  logic     alu_nz,
    input  logic     cmp_res,
    input  logic     bit_res,
    input  logic     restore,
    input  logic     pop_val,
    output logic     flag_q
);
    logic nxt;
    logic hit;

    always_comb begin
        nxt = flag_q;
        hit = 1'b0;
        unique case (op)
            OP_ARITH_CY: begin nxt = alu_carry; hit = 1'b1; end
            OP_ARITH_NZ: begin nxt = alu_nz;    hit = 1'b1; end
            OP_COMPARE:  begin nxt = cmp_res;   hit = 1'b1; end
            OP_BITTEST:  begin nxt = bit_res;   hit = 1'b1; end
            OP_BRANCH:   begin nxt = 1'b1;      hit = 1'b1; end
            default:     begin nxt = flag_q;    hit = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (restore) begin
            flag_q <= pop_val;
        end else if (upd_en && hit) begin
            flag_q <= nxt;
        end
    end
endmodule

// File: rtl/carry_status_flags.sv
module carry_status_flags
    import flagu_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic [OP_W-1:0]   op_cls,
    input  logic              alu_carry,
    input  logic              alu_nonzero,
    input  logic              cmp_result,
    input  logic              bit_result,
    input  logic [DATA_W-1:0] acc_val,
    input  logic              rti_restore,
    input  logic              pop_carry,
    input  logic              pop_status,
    output logic              carry_flag,
    output logic              status_flag,
    output logic              ctx_carry,
    output logic              ctx_status,
    output logic              branch_cond
);
    flag_op_e op_dec;
    logic     ca_q;
    logic     st_q;

    assign op_dec = flag_op_e'(op_cls);

    flagu_carry #(.DATA_W(DATA_W)) u_carry (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (instr_done),
        .op        (op_dec),
        .alu_carry (alu_carry),
        .acc       (acc_val),
        .restore   (rti_restore),
        .pop_val   (pop_carry),
        .flag_q    (ca_q)
    );

    flagu_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (instr_done),
        .op        (op_dec),
        .alu_carry (alu_carry),
        .alu_nz    (alu_nonzero),
        .cmp_res   (cmp_result),
        .bit_res   (bit_result),
        .restore   (rti_restore),
        .pop_val   (pop_status),
        .flag_q    (st_q)
    );

    assign carry_flag  = ca_q;
    assign status_flag = st_q;
    assign ctx_carry   = ca_q;
    assign ctx_status  = st_q;
    assign branch_cond = st_q;
endmodule

// File: rtl/carry_status_flags_chk.sv
module carry_status_flags_chk
    import flagu_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_done,
    input logic [OP_W-1:0]   op_cls,
    input logic              alu_carry,
    input logic              alu_nonzero,
    input logic              cmp_result,
    input logic              bit_result,
    input logic [DATA_W-1:0] acc_val,
    input logic              rti_restore,
    input logic              pop_carry,
    input logic              pop_status,
    input logic              carry_flag,
    input logic              status_flag
);
    logic upd;
    assign upd = instr_done && !rti_restore;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_zero_r1: assert (carry_flag == 1'b0 && status_flag == 1'b0);
        end
    end

    p_arith_cy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd && op_cls == OP_ARITH_CY |=>
            carry_flag == $past(alu_carry) && status_flag == $past(alu_carry));

    p_arith_nz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd && op_cls == OP_ARITH_NZ |=>
            status_flag == $past(alu_nonzero) && $stable(carry_flag));

    p_compare_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd && op_cls == OP_COMPARE |=>
            status_flag == $past(cmp_result) && $stable(carry_flag));

    p_bittest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd && op_cls == OP_BITTEST |=>
            status_flag == $past(bit_result) && $stable(carry_flag));

    p_set_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd && (op_cls == OP_SET_CY || op_cls == OP_CLR_CY) |=>
            carry_flag == ($past(op_cls) == OP_SET_CY) && $stable(status_flag));

    p_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd && (op_cls == OP_ROT_L || op_cls == OP_ROT_R) |=>
            carry_flag == (($past(op_cls) == OP_ROT_L) ? $past(acc_val[DATA_W-1])
                                                       : $past(acc_val[0]))
            && $stable(status_flag));

    p_branch_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd && op_cls == OP_BRANCH |=> status_flag && $stable(carry_flag));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rti_restore && (!instr_done || op_cls == OP_NOP || op_cls >= OP_RETURN) |=>
            $stable(carry_flag) && $stable(status_flag));

    p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rti_restore |=>
            carry_flag == $past(pop_carry) && status_flag == $past(pop_status));
endmodule

bind carry_status_flags carry_status_flags_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_done  (instr_done),
    .op_cls      (op_cls),
    .alu_carry   (alu_carry),
    .alu_nonzero (alu_nonzero),
    .cmp_result  (cmp_result),
    .bit_result  (bit_result),
    .acc_val     (acc_val),
    .rti_restore (rti_restore),
    .pop_carry   (pop_carry),
    .pop_status  (pop_status),
    .carry_flag  (carry_flag),
    .status_flag (status_flag)
);

// File: tb/carry_status_flags_tb.sv
`timescale 1ns/1ps
module carry_status_flags_tb;
    localparam int DATA_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b1;
    logic              instr_done = 1'b0;
    logic [3:0]        op_cls = 4'd0;
    logic              alu_carry = 1'b0;
    logic              alu_nonzero = 1'b0;
    logic              cmp_result = 1'b0;
    logic              bit_result = 1'b0;
    logic [DATA_W-1:0] acc_val = '0;
    logic              rti_restore = 1'b0;
    logic              pop_carry = 1'b0;
    logic              pop_status = 1'b0;
    logic              carry_flag, status_flag, ctx_carry, ctx_status, branch_cond;

    int n_cmp = 0;
    int n_bad = 0;
    bit fin = 1'b0;
    logic m_ca = 1'b0;
    logic m_st = 1'b0;

    always #4 clk = ~clk;

    carry_status_flags #(.DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .op_cls(op_cls),
        .alu_carry(alu_carry), .alu_nonzero(alu_nonzero), .cmp_result(cmp_result),
        .bit_result(bit_result), .acc_val(acc_val), .rti_restore(rti_restore),
        .pop_carry(pop_carry), .pop_status(pop_status), .carry_flag(carry_flag),
        .status_flag(status_flag), .ctx_carry(ctx_carry), .ctx_status(ctx_status),
        .branch_cond(branch_cond)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic logic f_next_ca(logic ca, logic done, logic [3:0] op, logic cy,
                                       logic [DATA_W-1:0] acc, logic rti, logic pca);
        if (rti) return pca;
        if (!done) return ca;
        case (op)
            4'd1: return cy;
            4'd5: return 1'b1;
            4'd6: return 1'b0;
            4'd7: return acc[DATA_W-1];
            4'd8: return acc[0];
            default: return ca;
        endcase
    endfunction

    function automatic logic f_next_st(logic st, logic done, logic [3:0] op, logic cy,
                                       logic nz, logic cm, logic bt, logic rti, logic pst);
        if (rti) return pst;
        if (!done) return st;
        case (op)
            4'd1: return cy;
            4'd2: return nz;
            4'd3: return cm;
            4'd4: return bt;
            4'd9: return 1'b1;
            default: return st;
        endcase
    endfunction

    function automatic string f_tag(logic done, logic [3:0] op, logic rti);
        if (rti) return "R9";
        if (!done) return "R8";
        case (op)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3, 4'd4: return "R4";
            4'd5, 4'd6: return "R5";
            4'd7, 4'd8: return "R6";
            4'd9: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Called at a falling edge: drive, advance the model, check at the next falling edge.
    task automatic step(logic done, logic [3:0] op, logic cy, logic nz, logic cm, logic bt,
                        logic [DATA_W-1:0] acc, logic rti, logic pca, logic pst);
        string tag;
        instr_done = done; op_cls = op; alu_carry = cy; alu_nonzero = nz;
        cmp_result = cm; bit_result = bt; acc_val = acc;
        rti_restore = rti; pop_carry = pca; pop_status = pst;
        tag  = f_tag(done, op, rti);
        m_ca = f_next_ca(m_ca, done, op, cy, acc, rti, pca);
        m_st = f_next_st(m_st, done, op, cy, nz, cm, bt, rti, pst);
        @(negedge clk);
        chk(tag, "carry_flag", carry_flag, m_ca);
        chk(tag, "status_flag", status_flag, m_st);
        chk("R10", "branch_cond", branch_cond, m_st);
        chk("R10", "ctx_carry", ctx_carry, m_ca);
        chk("R10", "ctx_status", ctx_status, m_st);
    endtask

    initial begin
        #(64'd8 * 200000);
        if (!fin) begin
            fin = 1'b1;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung, expected finished run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #2 rst_n = 1'b0;
        // R1: flag-changing stimulus while reset is held
        instr_done = 1'b1; op_cls = 4'd5; rti_restore = 1'b1;
        pop_carry = 1'b1; pop_status = 1'b1; alu_carry = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "carry_flag", carry_flag, 1'b0);
        chk("R1", "status_flag", status_flag, 1'b0);
        instr_done = 1'b0; rti_restore = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "carry_flag after release", carry_flag, 1'b0);

        // directed corners
        step(1, 4'd5, 0, 0, 0, 0, 4'h0, 0, 0, 0);  // R5 set
        step(1, 4'd9, 0, 0, 0, 0, 4'h0, 0, 0, 0);  // R7 force st
        step(1, 4'd6, 1, 1, 1, 1, 4'hF, 0, 0, 0);  // R5 clear
        step(1, 4'd7, 0, 0, 0, 0, 4'h8, 0, 0, 0);  // R6 rotl msb=1
        step(1, 4'd8, 1, 0, 0, 0, 4'h8, 0, 0, 0);  // R6 rotr lsb=0
        step(1, 4'd8, 0, 0, 0, 0, 4'h1, 0, 0, 0);  // R6 rotr lsb=1
        step(1, 4'd1, 0, 1, 1, 1, 4'h0, 0, 0, 0);  // R2 cy=0
        step(1, 4'd2, 1, 1, 0, 0, 4'h0, 0, 0, 0);  // R3
        step(1, 4'd3, 1, 0, 0, 1, 4'h0, 0, 0, 0);  // R4 compare 0
        step(1, 4'd4, 0, 0, 1, 1, 4'h0, 0, 0, 0);  // R4 bit test 1
        step(1, 4'd10, 0, 0, 0, 0, 4'h0, 0, 1, 0); // R8 plain return ignores pop values
        step(1, 4'd15, 1, 1, 1, 1, 4'hF, 0, 0, 0); // R8 unused code
        step(0, 4'd1, 1, 1, 1, 1, 4'hF, 0, 0, 0);  // R8 no done
        step(1, 4'd5, 1, 1, 1, 1, 4'hF, 1, 0, 0);  // R9 restore beats set
        step(1, 4'd9, 1, 1, 1, 1, 4'hF, 1, 1, 0);  // R9 restore beats branch force
        step(0, 4'd0, 0, 0, 0, 0, 4'h0, 1, 1, 1);  // R9 restore without done
        step(1, 4'd1, 0, 0, 0, 0, 4'h0, 0, 1, 1);  // R2 cy=0 clears both

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[0] | r[1], r[5:2], r[6], r[7], r[8], r[9], r[13:10],
                 (r[16:14] == 3'd0), r[17], r[18]);
        end

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule